// File: doc/BRIEF.md
# Byte Transmit Handshake for a Parallel Instrument Bus

This block is the sending half of a three-wire, byte-wide handshake on a shared instrument bus. Local logic offers one byte at a time over a valid/ready pair, together with a flag that marks the final byte of a message. The block places the byte on the data lines and holds it there for a programmable settling time. It then raises the data-valid strobe once every listener has stopped holding the not-ready line. It drops the strobe once every listener has stopped holding the not-accepted line.

The two listener lines are wire-ORed on the bus, so the slowest listener decides how fast each byte goes. The end-of-message line is driven alongside the final byte. Only the current talker drives the data lines, the strobe and the end line. When local logic withdraws talker status, all three are released in the same cycle. When the bus-wide clear line is asserted, they are released as soon as that line has passed the input synchronizer. If both listener lines are seen released while a byte waits to be strobed, no listener can be present: the block flags an error and drops the byte. All three bus inputs pass through a two-flop synchronizer.

Top module: `bus_src_hs`

## Requirements
- R1: After reset, with talker status held, `bus_oe`, `dav`, `eoi` and `no_lsn_err` are 0, `bus_data` is 0 and `tx_ready` is 1.
- R2: A byte taken on a clock edge where `tx_valid` and `tx_ready` are both 1 appears on `bus_data` with `bus_oe` high from that edge on. If `nrfd_in` is low and `ndac_in` is high, `dav` rises exactly `settle_cycles`+1 clock edges after the accepting edge.
- R3: `dav` never rises while the synchronized `nrfd_in` is high. A byte stays on the lines with `dav` low until `nrfd_in` goes low.
- R4: While `dav` is high, `bus_data` and `eoi` do not change.
- R5: `dav` falls only after `ndac_in` has gone low. It falls on the third rising edge after `ndac_in` goes low, and `eoi` and `bus_oe` fall with it.
- R6: `eoi` is high with a byte exactly when that byte was offered with `tx_last` = 1.
- R7: `tx_ready` is 0 from the accepting edge until `dav` has fallen, and `dav` is never high while `tx_ready` is 1.
- R8: If the synchronized `nrfd_in` and `ndac_in` are both low before `dav` has been raised for a byte, `no_lsn_err` pulses high for one cycle. The byte is dropped, `dav` never rises for it, and the lines are released.
- R9: When `talk_en` goes low, `dav`, `eoi`, `bus_oe` and `bus_data` are released in the same cycle, `tx_ready` goes low, and the pending byte is dropped.
- R10: When `ifc_in` goes high, the lines are still driven after the first rising edge and are released after the second. The pending byte is dropped, and `tx_ready` returns once `ifc_in` is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | DW | Byte offered by local logic |
| tx_last | input | 1 | Offered byte ends the message |
| tx_valid | input | 1 | Byte offer valid |
| tx_ready | output | 1 | Block can take a byte |
| settle_cycles | input | SW | Extra settling cycles before the strobe |
| talk_en | input | 1 | Local talker status |
| ifc_in | input | 1 | Bus-wide clear line, asynchronous |
| nrfd_in | input | 1 | Wire-ORed not-ready line, high = some listener not ready |
| ndac_in | input | 1 | Wire-ORed not-accepted line, high = some listener not done |
| bus_data | output | DW | Data lines, zero when released |
| bus_oe | output | 1 | Data lines driven |
| dav | output | 1 | Data-valid strobe |
| eoi | output | 1 | End-of-message line |
| no_lsn_err | output | 1 | One-cycle pulse: no listener present |

## Verification
A corrupted state or settle counter shows up at the ports within one handshake. The strobe rises off its exact settle+1 edge, data moves while the strobe is high, or the strobe drops before the three-edge delay after accept. A listener model in the bench captures every strobed byte, so a lost, repeated or mis-flagged byte shows as a wrong capture value or count. The release paths are checked in the cycle they must act: the same cycle for loss of talker status, and the second edge for the clear line.

// File: rtl/bus_src_hs.sv
module bus_src_hs #(
  parameter int DW = 8,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_last,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [SW-1:0] settle_cycles,
  input  logic          talk_en,
  input  logic          ifc_in,
  input  logic          nrfd_in,
  input  logic          ndac_in,
  output logic [DW-1:0] bus_data,
  output logic          bus_oe,
  output logic          dav,
  output logic          eoi,
  output logic          no_lsn_err
);

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_DAV} st_t;

  st_t           st;
  logic [SW-1:0] cnt;
  logic [DW-1:0] data_q;
  logic          last_q;
  logic [2:0]    sy1, sy2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
    end else begin
      sy1 <= {ifc_in, nrfd_in, ndac_in};
      sy2 <= sy1;
    end
  end

  logic ifc_s, nrfd_s, ndac_s, active;
  assign ifc_s  = sy2[2];
  assign nrfd_s = sy2[1];
  assign ndac_s = sy2[0];
  assign active = talk_en && !ifc_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      data_q     <= '0;
      last_q     <= 1'b0;
      no_lsn_err <= 1'b0;
    end else begin
      no_lsn_err <= 1'b0;
      if (!active) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (tx_valid) begin
            data_q <= tx_data;
            last_q <= tx_last;
            cnt    <= settle_cycles;
            st     <= S_SETTLE;
          end
          S_SETTLE: begin
            if (!nrfd_s && !ndac_s) begin
              no_lsn_err <= 1'b1;
              st         <= S_IDLE;
            end else if (cnt != '0) begin
              cnt <= cnt - 1'b1;
            end else if (!nrfd_s) begin
              st <= S_DAV;
            end
          end
          S_DAV: if (!ndac_s) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign tx_ready = active && (st == S_IDLE);
  assign bus_oe   = active && (st != S_IDLE);
  assign bus_data = bus_oe ? data_q : '0;
  assign dav      = active && (st == S_DAV);
  assign eoi      = bus_oe && last_q;

  assert_dav_after_nrfd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dav) |-> $past(!nrfd_s));

  assert_data_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dav && $past(dav)) |-> ($stable(bus_data) && $stable(eoi)));

  assert_drop_after_ndac_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dav) && talk_en && !ifc_s) |-> $past(!ndac_s));

  assert_ready_excl_dav_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !dav);

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    no_lsn_err |-> (!dav && !bus_oe));

endmodule

// File: tb/tb_bus_src_hs.sv
module tb_bus_src_hs;
  logic       clk = 0, rst_n = 0;
  logic [7:0] tx_data = 0;
  logic       tx_last = 0, tx_valid = 0;
  logic [3:0] settle = 0;
  logic       talk_en = 1, ifc = 0, nrfd = 0, ndac = 1;
  logic       tx_ready, bus_oe, dav, eoi, no_lsn_err;
  logic [7:0] bus_data;

  bus_src_hs #(.DW(8), .SW(4)) dut (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_last(tx_last), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .settle_cycles(settle), .talk_en(talk_en), .ifc_in(ifc),
    .nrfd_in(nrfd), .ndac_in(ndac), .bus_data(bus_data), .bus_oe(bus_oe), .dav(dav),
    .eoi(eoi), .no_lsn_err(no_lsn_err));

  always #5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0, done = 0;
  int lsn_mode = 0, lsn_delay = 0, lcnt = 0, ncap = 0, t_ack = 0, stab_bad = 0;
  logic [7:0] cap_data = 0, prev_data = 0;
  logic cap_eoi = 0, ack_pend = 0, prev_dav = 0, prev_eoi = 0;

  localparam int NV = 6;
  localparam logic [7:0] V_DATA [NV] = '{8'hA5, 8'h3C, 8'h00, 8'hFF, 8'h81, 8'h5E};
  localparam logic       V_LAST [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [3:0] V_SET  [NV] = '{4'd0, 4'd3, 4'd1, 4'd7, 4'd15, 4'd2};
  localparam int         V_DLY  [NV] = '{0, 2, 5, 1, 0, 4};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // listener model on the bus inputs
  initial forever begin
    @(negedge clk);
    case (lsn_mode)
      1: begin nrfd = 0; ndac = 0; end
      2: begin nrfd = 1; ndac = 1; end
      default: begin
        if (dav && ndac) begin
          nrfd = 1;
          if (lcnt >= lsn_delay) begin
            ndac = 0; cap_data = bus_data; cap_eoi = eoi; ncap++;
            t_ack = cyc; ack_pend = 1;
          end else lcnt++;
        end else if (!dav && !ndac) begin
          ndac = 1; nrfd = 0; lcnt = 0;
        end else if (!dav && ndac) begin
          nrfd = 0; lcnt = 0;
        end
      end
    endcase
  end

  // monitor: frozen data while strobe high, strobe drop timing
  initial forever begin
    @(negedge clk);
    if (prev_dav && dav && (bus_data != prev_data || eoi != prev_eoi)) stab_bad++;
    if (prev_dav && !dav && ack_pend) begin
      chk(cyc - t_ack == 3, "R5 dav drop edge after ndac release", cyc - t_ack, 3);
      chk(!eoi && !bus_oe, "R5 eoi/oe fall with dav", {eoi, bus_oe}, 0);
      ack_pend = 0;
    end
    prev_dav = dav; prev_data = bus_data; prev_eoi = eoi;
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
    finish_run();
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic l, input logic [3:0] s);
    int w = 0;
    while (!tx_ready && w < 100) begin w++; @(negedge clk); end
    tx_data = d; tx_last = l; settle = s; tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
    chk(tx_ready == 0, "R7 ready low after accept", tx_ready, 0);
  endtask

  task automatic wait_dav(output int g);
    g = 0;
    while (!dav && g < 200) begin g++; @(negedge clk); end
  endtask

  initial begin
    int g, n0, w;
    idle(3);
    rst_n = 1;
    idle(3);
    chk(!bus_oe && !dav && !eoi && !no_lsn_err, "R1 outputs released", {bus_oe, dav, eoi, no_lsn_err}, 0);
    chk(bus_data == 0, "R1 data zero", bus_data, 0);
    chk(tx_ready == 1, "R1 ready", tx_ready, 1);

    for (int v = 0; v < NV; v++) begin
      lsn_delay = V_DLY[v];
      n0 = ncap;
      send(V_DATA[v], V_LAST[v], V_SET[v]);
      chk(bus_oe && bus_data == V_DATA[v], "R2 byte on lines", bus_data, V_DATA[v]);
      chk(eoi == V_LAST[v], "R6 eoi with byte", eoi, V_LAST[v]);
      wait_dav(g);
      chk(g == V_SET[v] + 1, "R2 settle gap", g, V_SET[v] + 1);
      w = 0;
      while ((dav || ncap == n0) && w < 200) begin w++; @(negedge clk); end
      chk(ncap == n0 + 1, "R5 one capture", ncap, n0 + 1);
      chk(cap_data == V_DATA[v], "R2 captured data", cap_data, V_DATA[v]);
      chk(cap_eoi == V_LAST[v], "R6 captured eoi", cap_eoi, V_LAST[v]);
      chk(tx_ready == 1, "R7 ready after dav fall", tx_ready, 1);
      idle(4);
    end
    chk(stab_bad == 0, "R4 data frozen while dav", stab_bad, 0);

    // R3: not-ready held by a listener
    lsn_mode = 2; lsn_delay = 1; idle(4);
    n0 = ncap;
    send(8'h77, 1'b0, 4'd2);
    idle(20);
    chk(!dav && bus_oe && bus_data == 8'h77, "R3 dav held off by nrfd", dav, 0);
    lsn_mode = 0;
    wait_dav(g);
    chk(dav == 1, "R3 dav after nrfd release", dav, 1);
    w = 0;
    while ((dav || ncap == n0) && w < 200) begin w++; @(negedge clk); end
    chk(ncap == n0 + 1 && cap_data == 8'h77, "R3 byte delivered", cap_data, 8'h77);
    idle(4);

    // R8: no listener present
    lsn_mode = 1; idle(4);
    n0 = ncap;
    send(8'h12, 1'b1, 4'd3);
    g = 0;
    w = 0;
    while (!no_lsn_err && w < 20) begin
      if (dav) g = 1;
      w++; @(negedge clk);
    end
    chk(no_lsn_err == 1, "R8 error pulse", no_lsn_err, 1);
    chk(!dav && !bus_oe && !eoi, "R8 lines released", {dav, bus_oe, eoi}, 0);
    @(negedge clk);
    chk(no_lsn_err == 0 && tx_ready == 1, "R8 pulse one cycle, ready", {no_lsn_err, tx_ready}, 1);
    chk(g == 0 && ncap == n0, "R8 byte dropped", ncap, n0);
    lsn_mode = 0; idle(4);

    // R9: loss of talker status mid-strobe
    lsn_delay = 30;
    n0 = ncap;
    send(8'hC3, 1'b1, 4'd0);
    wait_dav(g);
    idle(2);
    talk_en = 0;
    #1;
    chk(!dav && !eoi && !bus_oe && bus_data == 0, "R9 immediate release", {dav, eoi, bus_oe}, 0);
    chk(tx_ready == 0, "R9 ready low", tx_ready, 0);
    idle(3);
    talk_en = 1;
    idle(3);
    chk(!dav && !bus_oe && tx_ready, "R9 byte dropped", {dav, bus_oe, tx_ready}, 1);
    chk(ncap == n0, "R9 no capture", ncap, n0);
    idle(4);

    // R10: bus-wide clear through synchronizer
    n0 = ncap;
    send(8'h5A, 1'b1, 4'd0);
    wait_dav(g);
    idle(2);
    ifc = 1;
    @(negedge clk);
    chk(dav && bus_oe, "R10 still driven after first edge", {dav, bus_oe}, 3);
    @(negedge clk);
    chk(!dav && !bus_oe && !eoi, "R10 released after second edge", {dav, bus_oe, eoi}, 0);
    ifc = 0;
    idle(4);
    chk(!dav && tx_ready && ncap == n0, "R10 byte dropped, ready back", {dav, tx_ready}, 1);
    idle(4);
    lsn_delay = 0;

    finish_run();
  end
endmodule